// File: doc/BRIEF.md
# Asynchronous FSK Byte Receiver

This block sits behind an FSK demodulator and turns its digital bit stream into bytes. The line idles high. Each character opens with a low start bit, carries eight data bits with the least significant bit first, and ends with a high stop bit. The receiver oversamples the line at sixteen times the bit rate, which defaults to 1200 bit/s. It decides every bit by a majority vote of three samples taken around the middle of the bit. A byte that ends with a good stop bit is placed in a data register, and an interrupt request is raised for the host.

A separate digital input from a level comparator reports whether the carrier is above the reference level. While the carrier is low, the receiver will not begin a character, and it drops any character it is part way through, so that noise is not taken as data. The host reads the data register and the status register through two read strobes. A data read clears the interrupt request. A status read clears the two sticky error flags: overrun and framing. The status register also shows the live carrier-low condition.

Top module: `fsk_byte_rx`

## Requirements
- R1: A character is one low start bit, then eight data bits with D0 first and D7 last, then one stop bit. After a character with a high stop bit, `data_out` holds the eight data bits, and `data_out` changes at no other time.
- R2: `irq` rises in the cycle after a valid character is stored. It falls in the cycle after a `rd_data_stb` pulse. If a new valid character is stored in the same cycle as a data read, `irq` stays high.
- R3: Status bit 3 (overrun) is set when a valid character is stored while `irq` is still high and no data read happens in that cycle. The new character replaces the unread one.
- R4: Status bit 2 (framing) is set when the majority vote of the stop bit is low. That character is discarded: `data_out` keeps its old value and `irq` does not change.
- R5: Both error flags are sticky. A `rd_status_stb` pulse clears them, but a set in the same cycle takes priority. A data read does not clear them.
- R6: While the synchronized `carrier_ok` is low, no character is started. A character in progress is abandoned at the next sample tick, and it produces no data, no `irq` and no error flag.
- R7: Status bit 4 is 1 while `carrier_ok` is low. It follows the input after a two-flop synchronizer.
- R8: A start bit whose mid-bit majority vote is high is treated as noise. The receiver goes back to idle without setting any flag.
- R9: A single-sample glitch inside the three-sample vote window of any bit does not change the received value.
- R10: After reset, `irq` is 0, `data_out` is 0x00 and `status_out` is 0x00 while the carrier is present.
- R11: Status bits 7 to 5 and 1 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronized inside the block |
| rx_in | input | 1 | Demodulated serial FSK bit stream; idles high |
| carrier_ok | input | 1 | 1 when the carrier level is above the reference |
| rd_data_stb | input | 1 | One-cycle pulse: the host reads the data register |
| rd_status_stb | input | 1 | One-cycle pulse: the host reads the status register |
| data_out | output | 8 | Last valid received byte |
| status_out | output | 8 | Bit 4 carrier low, bit 3 overrun, bit 2 framing; other bits 0 |
| irq | output | 1 | Interrupt request: an unread valid byte is waiting |

## Verification
Some rules are checked on every clock cycle by the assertions:
- how `irq` rises and falls around stored characters and data reads;
- that each error flag is set only by its own cause and cleared only by a status read;
- that `data_out` holds between stored characters;
- that the framer goes idle after a sample tick with the carrier low.

Other behaviour needs whole waveforms and is shown only by the bench's scenarios: the bit order of the received byte, the majority vote against a one-sample glitch, the rejection of a false start, and the loss of a character when the carrier drops in the middle of it.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  localparam int OSR        = 16;
  localparam int OSR_W      = 4;
  localparam int VOTE_FIRST = 7;
  localparam int VOTE_LAST  = 9;
  localparam int DECIDE_AT  = 10;

  localparam int ST_FRM_BIT  = 2;
  localparam int ST_OVR_BIT  = 3;
  localparam int ST_CLOW_BIT = 4;
endpackage

// File: rtl/fsk_rx_tick.sv
module fsk_rx_tick #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;
    end
  endgenerate
endmodule

// File: rtl/fsk_rx_sync.sv
module fsk_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= RST_VAL;
          else        pipe_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[i] <= RST_VAL;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/fsk_rx_framer.sv
module fsk_rx_framer
  import fsk_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              car_ok,
  output logic              byte_ok,
  output logic              frame_bad,
  output logic [DATA_W-1:0] byte_val,
  output logic              busy
);
  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BC_W-1:0]  LAST_BIT = BC_W'(DATA_W - 1);
  localparam logic [OSR_W-1:0] S_FIRST  = OSR_W'(VOTE_FIRST);
  localparam logic [OSR_W-1:0] S_LAST   = OSR_W'(VOTE_LAST);
  localparam logic [OSR_W-1:0] S_DEC    = OSR_W'(DECIDE_AT);
  localparam logic [OSR_W-1:0] S_END    = OSR_W'(OSR - 1);

  rx_state_t          st_q, st_d;
  logic [OSR_W-1:0]   smp_q, smp_d;
  logic [BC_W-1:0]    bit_q, bit_d;
  logic [2:0]         win_q, win_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               ok_d, bad_d, ok_q, bad_q;
  logic               vote;

  always_comb begin
    vote = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
  end

  always_comb begin
    st_d  = st_q;
    smp_d = smp_q;
    bit_d = bit_q;
    win_d = win_q;
    sh_d  = sh_q;
    ok_d  = 1'b0;
    bad_d = 1'b0;
    if (tick) begin
      if (st_q == RX_IDLE) begin
        if (!line && car_ok) begin
          st_d  = RX_START;
          smp_d = OSR_W'(1);
          win_d = '0;
        end
      end else if (!car_ok) begin
        st_d = RX_IDLE;
      end else begin
        smp_d = smp_q + 1'b1;
        if (smp_q >= S_FIRST && smp_q <= S_LAST)
          win_d = {win_q[1:0], line};
        if (smp_q == S_DEC) begin
          unique case (st_q)
            RX_START: if (vote) st_d = RX_IDLE;
            RX_DATA:  sh_d = {vote, sh_q[DATA_W-1:1]};
            RX_STOP: begin
              st_d  = RX_IDLE;
              ok_d  = vote;
              bad_d = !vote;
            end
            default: st_d = RX_IDLE;
          endcase
        end
        if (smp_q == S_END) begin
          if (st_q == RX_START) begin
            st_d  = RX_DATA;
            bit_d = '0;
          end else if (st_q == RX_DATA) begin
            if (bit_q == LAST_BIT) st_d = RX_STOP;
            else                   bit_d = bit_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      smp_q <= '0;
      bit_q <= '0;
      win_q <= '0;
      sh_q  <= '0;
    end else if (tick) begin
      st_q  <= st_d;
      smp_q <= smp_d;
      bit_q <= bit_d;
      win_q <= win_d;
      sh_q  <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      bad_q <= bad_d;
    end
  end

  assign byte_ok   = ok_q;
  assign frame_bad = bad_q;
  assign byte_val  = sh_q;
  assign busy      = (st_q != RX_IDLE);
endmodule

// File: rtl/fsk_rx_regs.sv
module fsk_rx_regs
  import fsk_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_ok,
  input  logic              frame_bad,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              rd_data,
  input  logic              rd_status,
  input  logic              car_low,
  output logic [DATA_W-1:0] data_q,
  output logic [7:0]        status,
  output logic              irq
);
  logic [DATA_W-1:0] data_r, data_d;
  logic              irq_q, irq_d;
  logic              ovr_q, ovr_d;
  logic              frm_q, frm_d;
  logic              ovr_set;

  always_comb begin
    ovr_set = byte_ok && irq_q && !rd_data;
    data_d  = byte_ok ? byte_val : data_r;
    if (byte_ok)      irq_d = 1'b1;
    else if (rd_data) irq_d = 1'b0;
    else              irq_d = irq_q;
    if (ovr_set)        ovr_d = 1'b1;
    else if (rd_status) ovr_d = 1'b0;
    else                ovr_d = ovr_q;
    if (frame_bad)      frm_d = 1'b1;
    else if (rd_status) frm_d = 1'b0;
    else                frm_d = frm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      data_r <= data_d;
      irq_q  <= irq_d;
      ovr_q  <= ovr_d;
      frm_q  <= frm_d;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_FRM_BIT]  = frm_q;
    status[ST_OVR_BIT]  = ovr_q;
    status[ST_CLOW_BIT] = car_low;
  end

  assign data_q = data_r;
  assign irq    = irq_q;
endmodule

// File: rtl/fsk_byte_rx.sv
module fsk_byte_rx
  import fsk_rx_pkg::*;
#(
  parameter int CLK_HZ      = 19_660_800,
  parameter int BAUD        = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       carrier_ok,
  input  logic       rd_data_stb,
  input  logic       rd_status_stb,
  output logic [7:0] data_out,
  output logic [7:0] status_out,
  output logic       irq
);
  localparam int DIV = CLK_HZ / (BAUD * OSR);

  logic [1:0] rst_q;
  logic       rst_int_n;
  logic       tick, rx_s, car_s;
  logic       byte_ok, frame_bad, busy;
  logic [7:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  fsk_rx_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  fsk_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rx (
    .clk(clk), .rst_n(rst_int_n), .d(rx_in), .q(rx_s)
  );

  fsk_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_car (
    .clk(clk), .rst_n(rst_int_n), .d(carrier_ok), .q(car_s)
  );

  fsk_rx_framer #(.DATA_W(8)) u_framer (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .line(rx_s), .car_ok(car_s),
    .byte_ok(byte_ok), .frame_bad(frame_bad), .byte_val(byte_val), .busy(busy)
  );

  fsk_rx_regs #(.DATA_W(8)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .byte_ok(byte_ok), .frame_bad(frame_bad),
    .byte_val(byte_val), .rd_data(rd_data_stb), .rd_status(rd_status_stb),
    .car_low(!car_s), .data_q(data_out), .status(status_out), .irq(irq)
  );
endmodule

// File: rtl/fsk_byte_rx_chk.sv
module fsk_byte_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data_stb,
  input logic       rd_status_stb,
  input logic [7:0] data_out,
  input logic [7:0] status_out,
  input logic       irq,
  input logic       byte_ok,
  input logic       frame_bad,
  input logic       busy,
  input logic       tick,
  input logic       car_s
);
  a_r2_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(byte_ok));

  a_r2_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_data_stb));

  a_r3_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && irq && !rd_data_stb) |=> status_out[3]);

  a_r5_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_out[3]) |-> $past(rd_status_stb));

  a_r5_frm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_out[2]) |-> $past(rd_status_stb));

  a_r4_frm_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_out[2]) |-> $past(frame_bad));

  a_r4_bad_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |-> !byte_ok);

  a_r1_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ok |=> $stable(data_out));

  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !car_s) |=> !busy);
endmodule

bind fsk_byte_rx fsk_byte_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data_stb(rd_data_stb),
  .rd_status_stb(rd_status_stb), .data_out(data_out),
  .status_out(status_out), .irq(irq), .byte_ok(byte_ok),
  .frame_bad(frame_bad), .busy(busy), .tick(tick), .car_s(car_s)
);

// File: tb/fsk_byte_rx_test.sv
module fsk_byte_rx_test;
  localparam int DIV  = 4;
  localparam int BAUD = 1200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       carrier_ok = 1'b1;
  logic       rd_data_stb = 1'b0;
  logic       rd_status_stb = 1'b0;
  logic [7:0] data_out, status_out;
  logic       irq;

  int n_checks = 0;
  int n_fails  = 0;
  logic [7:0] m_data = 8'h00;
  logic       m_irq = 1'b0, m_ovr = 1'b0, m_frm = 1'b0;
  logic       finished = 1'b0;

  always #2.5 clk = ~clk;

  fsk_byte_rx #(.CLK_HZ(DIV * 16 * BAUD), .BAUD(BAUD)) uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .carrier_ok(carrier_ok),
    .rd_data_stb(rd_data_stb), .rd_status_stb(rd_status_stb),
    .data_out(data_out), .status_out(status_out), .irq(irq)
  );

  function automatic logic [7:0] exp_status(logic ovr, logic frm, logic clow);
    logic [7:0] s;
    s = 8'h00;
    s[3] = ovr;
    s[2] = frm;
    s[4] = clow;
    return s;
  endfunction

  function automatic logic line_level(logic [7:0] b, int k, logic stop_v);
    if (k == 0) return 1'b0;
    if (k == 9) return stop_v;
    return b[k-1];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R1 data"}, data_out, m_data);
    check({tag, " R2 irq"}, {7'b0, irq}, {7'b0, m_irq});
    check({tag, " R3/R4/R11 status"}, status_out, exp_status(m_ovr, m_frm, 1'b0));
  endtask

  // car_mode: 0 carrier present, 1 dropped over bits 3..6, 2 absent for the whole frame
  task automatic send_frame(logic [7:0] b, logic stop_v, int glitch_bit, int car_mode);
    for (int k = 0; k < 10; k++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        rx_in = line_level(b, k, stop_v) ^ ((k == glitch_bit) && (s == 8));
        carrier_ok = !((car_mode == 2) || (car_mode == 1 && k >= 3 && k <= 6));
        repeat (DIV - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    rx_in = 1'b1;
    carrier_ok = 1'b1;
    repeat (64) @(negedge clk);
  endtask

  task automatic good_frame(logic [7:0] b, int glitch_bit);
    send_frame(b, 1'b1, glitch_bit, 0);
    if (m_irq) m_ovr = 1'b1;
    m_irq = 1'b1;
    m_data = b;
  endtask

  task automatic read_data();
    @(negedge clk) rd_data_stb = 1'b1;
    @(negedge clk) rd_data_stb = 1'b0;
    m_irq = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_status(string tag);
    check({tag, " R5 status before clear"}, status_out, exp_status(m_ovr, m_frm, 1'b0));
    @(negedge clk) rd_status_stb = 1'b1;
    @(negedge clk) rd_status_stb = 1'b0;
    m_ovr = 1'b0;
    m_frm = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int gb;
    b = 8'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check_all("reset R10");

    good_frame(8'hA5, -1);
    check_all("directed R1 A5");
    good_frame(8'h01, -1);
    check_all("directed R1 01 overrun R3");
    read_data();
    check_all("after data read R2 R5");
    read_status("R5 clear overrun");
    check_all("after status read R5");

    good_frame(8'h80, 4);
    check_all("glitch R9 80");
    read_data();

    send_frame(8'h3C, 1'b0, -1, 0);
    m_frm = 1'b1;
    check_all("framing R4");
    read_status("R4 framing");

    @(negedge clk) rx_in = 1'b0;
    repeat (2 * DIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (160) @(negedge clk);
    check_all("false start R8");

    @(negedge clk) carrier_ok = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 carrier low bit", status_out, exp_status(m_ovr, m_frm, 1'b1));
    carrier_ok = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 carrier back", status_out, exp_status(m_ovr, m_frm, 1'b0));

    send_frame(8'h5A | 8'hC0, 1'b1, -1, 1);
    check_all("carrier drop mid R6");
    send_frame(8'h12, 1'b1, -1, 2);
    check_all("carrier absent R6");

    for (int i = 0; i < 24; i++) begin
      b = 8'($urandom);
      gb = ($urandom % 3 == 0) ? int'($urandom % 10) : -1;
      good_frame(b, gb);
      check_all("random R1 R9");
      if ($urandom % 3 != 0) read_data();
      if ($urandom % 4 == 0) read_status("random R5");
    end

    read_data();
    check_all("final R2");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule